// File: doc/BRIEF.md
# PCI Configuration Space Register File

This block holds the type-0 configuration header of a PCI audio function. A simple access port (write strobe, read strobe, dword address, 32-bit write data, four byte enables, 32-bit read data) reaches all 64 dwords of the 256-byte space. Identification and class codes are constants. The command bits, the memory base address, the interrupt line and the power state are writable. Error events from the rest of the function set sticky status bits, and software clears those bits by writing ones.

The subsystem vendor and subsystem IDs are read-only at their standard location. Firmware changes them only through a separate alias dword. A mode bit in a control dword hides or shows the power-management capability. When the capability is hidden, the capability pointer reads zero and the status capabilities-list bit is cleared. The memory enable, bus-master enable and current power state are brought out as ports for the rest of the function.

Top module: `pci_cfg_regfile`

## Requirements
- R1: Dword 00h reads 000C1073h and dword 08h reads 04010003h. Dword 0Ch reads zero. Writes to these dwords change nothing.
- R2: The command register (dword 04h bits 15:0) resets to 0. Only bits 1, 2, 6 and 8 are writable. mem_en follows bit 1 and bm_en follows bit 2.
- R3: Status bits 10:9 always read 01b. Input pulses set status bits 11 (ev_sig_tabort), 12 (ev_rcv_tabort), 13 (ev_rcv_mabort), 14 (ev_sig_serr) and 15 (ev_parity_err). Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When a set and a clear of the same bit arrive in the same cycle, the set wins.
- R4: Status bit 8 is set by an ev_master_dperr pulse only while command bit 6 is 1.
- R5: The base address at dword 10h has only bits 31:15 writable, and bits 14:0 read 0. Writing all ones reads back FFFF8000h.
- R6: Dword 2Ch reads {subsystem ID, subsystem vendor ID}. It resets to 000C1073h and ignores writes. A write to dword 44h loads the vendor ID through lanes 0-1 and the subsystem ID through lanes 2-3. Dword 44h reads zero.
- R7: Bit 0 of dword 58h is the capability-hide bit. It is writable and resets to 0. While it is 0, dword 34h reads 50h and status bit 4 reads 1. While it is 1, both read 0.
- R8: Dword 50h reads 04010001h. Bits 1:0 of dword 54h hold the power state: 00 for D0, 10 for D2 and 11 for D3. The power state resets to 00. A write of 01 leaves the state unchanged. pm_state shows the state.
- R9: Byte 3Ch (interrupt line) is writable and resets to 0. Byte 3Dh reads 01h, and bytes 3Eh-3Fh read 0.
- R10: Reserved dwords (14h-28h, 30h, 4Ch, 5Ch-FCh) read zero, and writes to them are discarded.
- R11: A write changes only the byte lanes whose enable is 1. Read data has zero in every lane whose enable was 0.
- R12: cfg_rdata changes only on the clock edge that samples cfg_rd. It then shows the register contents from before that edge, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe, one cycle per access |
| cfg_rd | input | 1 | Read strobe, one cycle per access |
| cfg_addr | input | 6 | Dword address (byte offset / 4) |
| cfg_be | input | 4 | Byte-lane enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| ev_master_dperr | input | 1 | Data parity error seen as master (pulse) |
| ev_sig_tabort | input | 1 | Target abort signalled (pulse) |
| ev_rcv_tabort | input | 1 | Target abort received (pulse) |
| ev_rcv_mabort | input | 1 | Master abort received (pulse) |
| ev_sig_serr | input | 1 | System error signalled (pulse) |
| ev_parity_err | input | 1 | Parity error detected (pulse) |
| mem_en | output | 1 | Memory space enable |
| bm_en | output | 1 | Bus master enable |
| pm_state | output | 2 | Current power state |

## Verification
Every state change from a write or an event pulse lands on the clock edge that samples it. The direct outputs mem_en, bm_en and pm_state are due in the following cycle. Read data leaves through one register, so it is valid one edge after cfg_rd and stays put until the next read. The bench drives each strobe for exactly one cycle, starting at a falling edge, and samples at the next falling edge. By then exactly one rising edge has passed, so each check sees the value that edge produced. The same-cycle collision between a set and a clear is forced by raising the event and the write strobe together.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
  localparam int DW_ADDR_W = 6;
  typedef logic [DW_ADDR_W-1:0] dw_addr_t;

  // dword indices (byte offset / 4); fixed by the header layout
  localparam dw_addr_t DW_ID     = 6'h00;
  localparam dw_addr_t DW_CMDSTS = 6'h01;
  localparam dw_addr_t DW_CLASS  = 6'h02;
  localparam dw_addr_t DW_BAR    = 6'h04;
  localparam dw_addr_t DW_SUBSYS = 6'h0B;
  localparam dw_addr_t DW_CAPPTR = 6'h0D;
  localparam dw_addr_t DW_INTR   = 6'h0F;
  localparam dw_addr_t DW_SSALI  = 6'h11;
  localparam dw_addr_t DW_PMHDR  = 6'h14;
  localparam dw_addr_t DW_PMCSR  = 6'h15;
  localparam dw_addr_t DW_MODE   = 6'h16;

  localparam logic [7:0]  PM_CAP_OFS = 8'h50;
  localparam logic [7:0]  PM_CAP_ID  = 8'h01;
  localparam logic [15:0] PM_CAPS    = 16'h0401; // D2 supported, spec version 1.0
  localparam logic [15:0] CMD_WMASK  = 16'h0146;
  localparam logic [15:0] STS_EVMASK = 16'hF900;

  // one byte of mask per enabled lane
  function automatic logic [31:0] lane_mask32(input logic [3:0] be);
    lane_mask32 = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] merge32(input logic [31:0] cur, input logic [31:0] nw,
                                          input logic [3:0] be, input logic [31:0] wmask);
    logic [31:0] m;
    m = lane_mask32(be) & wmask;
    merge32 = (cur & ~m) | (nw & m);
  endfunction

  function automatic logic [15:0] merge16(input logic [15:0] cur, input logic [15:0] nw,
                                          input logic [1:0] be, input logic [15:0] wmask);
    logic [15:0] m;
    m = {{8{be[1]}}, {8{be[0]}}} & wmask;
    merge16 = (cur & ~m) | (nw & m);
  endfunction

  // sticky bits: events set, ones written clear; a set beats a clear
  function automatic logic [15:0] sticky16(input logic [15:0] cur, input logic [15:0] set,
                                           input logic [15:0] clr);
    sticky16 = (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/cfg_cmd_status.sv
module cfg_cmd_status
  import cfg_space_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic        cap_list_on,
  input  logic        ev_master_dperr,
  input  logic        ev_sig_tabort,
  input  logic        ev_rcv_tabort,
  input  logic        ev_rcv_mabort,
  input  logic        ev_sig_serr,
  input  logic        ev_parity_err,
  output logic [15:0] cmd_q,
  output logic [15:0] sts_rd,
  output logic        per_en,
  output logic        dpd_bit
);
  localparam logic [15:0] STS_CONST = 16'h0200; // medium DEVSEL timing

  logic [15:0] sts_ev_q;
  logic [15:0] ev_set;
  logic [15:0] ev_clr;

  assign per_en  = cmd_q[6];
  assign ev_set  = {ev_parity_err, ev_sig_serr, ev_rcv_mabort, ev_rcv_tabort, ev_sig_tabort,
                    2'b00, ev_master_dperr & per_en, 8'h00};
  assign ev_clr  = wr_en ? (wdata[31:16] & {{8{be[3]}}, {8{be[2]}}} & STS_EVMASK) : 16'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      sts_ev_q <= '0;
    end else begin
      if (wr_en) cmd_q <= merge16(cmd_q, wdata[15:0], be[1:0], CMD_WMASK);
      sts_ev_q <= sticky16(sts_ev_q, ev_set, ev_clr) & STS_EVMASK;
    end
  end

  assign dpd_bit = sts_ev_q[8];
  assign sts_rd  = sts_ev_q | STS_CONST | {11'h0, cap_list_on, 4'h0};
endmodule

// File: rtl/cfg_id_bar.sv
module cfg_id_bar
  import cfg_space_pkg::*;
#(
  parameter int          BAR_SIZE_LOG2 = 15,
  parameter logic [15:0] SSVID_RST     = 16'h1073,
  parameter logic [15:0] SSID_RST      = 16'h000C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_bar,
  input  logic        wr_alias,
  input  logic        wr_intr,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] bar_q,
  output logic [31:0] subsys_q,
  output logic [7:0]  int_line_q
);
  localparam logic [31:0] BAR_WMASK = 32'hFFFF_FFFF << BAR_SIZE_LOG2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bar_q      <= '0;
      subsys_q   <= {SSID_RST, SSVID_RST};
      int_line_q <= '0;
    end else begin
      if (wr_bar)   bar_q    <= merge32(bar_q, wdata, be, BAR_WMASK);
      if (wr_alias) subsys_q <= merge32(subsys_q, wdata, be, 32'hFFFF_FFFF);
      if (wr_intr && be[0]) int_line_q <= wdata[7:0];
    end
  end
endmodule

// File: rtl/cfg_pm_cap.sv
module cfg_pm_cap (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_csr,
  input  logic       wr_mode,
  input  logic       be0,
  input  logic [1:0] wdata_lo,
  output logic [1:0] pm_state,
  output logic       cap_hide
);
  localparam logic [1:0] ST_D1 = 2'b01;

  logic state_ok;
  assign state_ok = (wdata_lo != ST_D1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pm_state <= 2'b00;
      cap_hide <= 1'b0;
    end else begin
      if (wr_csr && be0 && state_ok) pm_state <= wdata_lo;
      if (wr_mode && be0) cap_hide <= wdata_lo[0];
    end
  end
endmodule

// File: rtl/pci_cfg_regfile.sv
module pci_cfg_regfile
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] VEN_ID        = 16'h1073,
  parameter logic [15:0] DEV_ID        = 16'h000C,
  parameter logic [7:0]  REV_ID        = 8'h03,
  parameter logic [7:0]  PROG_IF       = 8'h00,
  parameter logic [7:0]  SUB_CLASS     = 8'h01,
  parameter logic [7:0]  BASE_CLASS    = 8'h04,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter int          BAR_SIZE_LOG2 = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic                 cfg_rd,
  input  logic [DW_ADDR_W-1:0] cfg_addr,
  input  logic [3:0]           cfg_be,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  input  logic                 ev_master_dperr,
  input  logic                 ev_sig_tabort,
  input  logic                 ev_rcv_tabort,
  input  logic                 ev_rcv_mabort,
  input  logic                 ev_sig_serr,
  input  logic                 ev_parity_err,
  output logic                 mem_en,
  output logic                 bm_en,
  output logic [1:0]           pm_state
);
  logic [15:0] cmd_q;
  logic [15:0] sts_rd;
  logic        per_en;
  logic        dpd_bit;
  logic [31:0] bar_q;
  logic [31:0] subsys_q;
  logic [7:0]  int_line_q;
  logic        cap_hide;
  logic [31:0] rd_mux;
  logic        wr_cmd, wr_bar, wr_alias, wr_intr, wr_csr, wr_mode;

  assign wr_cmd   = cfg_wr && (cfg_addr == DW_CMDSTS);
  assign wr_bar   = cfg_wr && (cfg_addr == DW_BAR);
  assign wr_alias = cfg_wr && (cfg_addr == DW_SSALI);
  assign wr_intr  = cfg_wr && (cfg_addr == DW_INTR);
  assign wr_csr   = cfg_wr && (cfg_addr == DW_PMCSR);
  assign wr_mode  = cfg_wr && (cfg_addr == DW_MODE);

  cfg_cmd_status u_cmdsts (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_cmd), .be(cfg_be), .wdata(cfg_wdata),
    .cap_list_on(!cap_hide),
    .ev_master_dperr(ev_master_dperr), .ev_sig_tabort(ev_sig_tabort),
    .ev_rcv_tabort(ev_rcv_tabort), .ev_rcv_mabort(ev_rcv_mabort),
    .ev_sig_serr(ev_sig_serr), .ev_parity_err(ev_parity_err),
    .cmd_q(cmd_q), .sts_rd(sts_rd), .per_en(per_en), .dpd_bit(dpd_bit)
  );

  cfg_id_bar #(.BAR_SIZE_LOG2(BAR_SIZE_LOG2), .SSVID_RST(VEN_ID), .SSID_RST(DEV_ID)) u_idbar (
    .clk(clk), .rst_n(rst_n), .wr_bar(wr_bar), .wr_alias(wr_alias), .wr_intr(wr_intr),
    .be(cfg_be), .wdata(cfg_wdata),
    .bar_q(bar_q), .subsys_q(subsys_q), .int_line_q(int_line_q)
  );

  cfg_pm_cap u_pm (
    .clk(clk), .rst_n(rst_n), .wr_csr(wr_csr), .wr_mode(wr_mode),
    .be0(cfg_be[0]), .wdata_lo(cfg_wdata[1:0]),
    .pm_state(pm_state), .cap_hide(cap_hide)
  );

  always_comb begin
    case (cfg_addr)
      DW_ID:     rd_mux = {DEV_ID, VEN_ID};
      DW_CMDSTS: rd_mux = {sts_rd, cmd_q};
      DW_CLASS:  rd_mux = {BASE_CLASS, SUB_CLASS, PROG_IF, REV_ID};
      DW_BAR:    rd_mux = bar_q;
      DW_SUBSYS: rd_mux = subsys_q;
      DW_CAPPTR: rd_mux = {24'h0, cap_hide ? 8'h00 : PM_CAP_OFS};
      DW_INTR:   rd_mux = {16'h0, INT_PIN, int_line_q};
      DW_PMHDR:  rd_mux = {PM_CAPS, 8'h00, PM_CAP_ID};
      DW_PMCSR:  rd_mux = {30'h0, pm_state};
      DW_MODE:   rd_mux = {31'h0, cap_hide};
      default:   rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_mux & lane_mask32(cfg_be);
  end

  assign mem_en = cmd_q[1];
  assign bm_en  = cmd_q[2];
endmodule

// File: rtl/cfg_regfile_chk.sv
module cfg_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic        cfg_rd,
  input logic [5:0]  cfg_addr,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        mem_en,
  input logic [1:0]  pm_state,
  input logic        ev_master_dperr,
  input logic        per_en,
  input logic        dpd_bit
);
  a_r2_mem_en_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_addr == 6'h01 && cfg_be[0] |=> mem_en == $past(cfg_wdata[1]));

  a_r8_never_d1: assert property (@(posedge clk) disable iff (!rst_n)
    pm_state != 2'b01);

  a_r3_devsel_medium: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd && cfg_addr == 6'h01 && cfg_be[3] |=> cfg_rdata[26:25] == 2'b01);

  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd |=> $stable(cfg_rdata));

  a_r11_lane0_off: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd && !cfg_be[0] |=> cfg_rdata[7:0] == 8'h00);

  a_r10_reserved_top: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd && cfg_addr >= 6'h17 |=> cfg_rdata == 32'h0);

  a_r4_dpd_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dpd_bit) |-> $past(per_en && ev_master_dperr));
endmodule

bind pci_cfg_regfile cfg_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
  .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_en(mem_en),
  .pm_state(pm_state), .ev_master_dperr(ev_master_dperr), .per_en(per_en), .dpd_bit(dpd_bit)
);

// File: tb/test_pci_cfg_regfile.sv
`timescale 1ns/1ps
module test_pci_cfg_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        ev_master_dperr = 1'b0, ev_sig_tabort = 1'b0, ev_rcv_tabort = 1'b0;
  logic        ev_rcv_mabort = 1'b0, ev_sig_serr = 1'b0, ev_parity_err = 1'b0;
  logic        mem_en, bm_en;
  logic [1:0]  pm_state;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pci_cfg_regfile i_pci_cfg_regfile (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ev_master_dperr(ev_master_dperr), .ev_sig_tabort(ev_sig_tabort),
    .ev_rcv_tabort(ev_rcv_tabort), .ev_rcv_mabort(ev_rcv_mabort),
    .ev_sig_serr(ev_sig_serr), .ev_parity_err(ev_parity_err),
    .mem_en(mem_en), .bm_en(bm_en), .pm_state(pm_state)
  );

  // {op(1=write), req, dword, be, data-or-expected}
  typedef logic [46:0] vec_t;
  localparam int NV = 49;
  localparam vec_t VEC [NV] = '{
    {1'b0, 4'd1,  6'h00, 4'hF, 32'h000C1073},  // R1
    {1'b1, 4'd1,  6'h00, 4'hF, 32'hFFFFFFFF},  // R1
    {1'b0, 4'd1,  6'h00, 4'hF, 32'h000C1073},  // R1
    {1'b0, 4'd1,  6'h02, 4'hF, 32'h04010003},  // R1
    {1'b0, 4'd1,  6'h03, 4'hF, 32'h00000000},  // R1
    {1'b0, 4'd3,  6'h01, 4'hF, 32'h02100000},  // R3 R7
    {1'b1, 4'd2,  6'h01, 4'hF, 32'hFFFFFFFF},  // R2
    {1'b0, 4'd2,  6'h01, 4'hF, 32'h02100146},  // R2
    {1'b1, 4'd11, 6'h01, 4'h1, 32'h00000000},  // R11
    {1'b0, 4'd11, 6'h01, 4'hF, 32'h02100100},  // R11
    {1'b0, 4'd11, 6'h01, 4'h3, 32'h00000100},  // R11
    {1'b0, 4'd11, 6'h01, 4'h4, 32'h00100000},  // R11
    {1'b1, 4'd5,  6'h04, 4'hF, 32'hFFFFFFFF},  // R5
    {1'b0, 4'd5,  6'h04, 4'hF, 32'hFFFF8000},  // R5
    {1'b1, 4'd11, 6'h04, 4'h8, 32'h12345678},  // R11
    {1'b0, 4'd11, 6'h04, 4'hF, 32'h12FF8000},  // R11
    {1'b0, 4'd6,  6'h0B, 4'hF, 32'h000C1073},  // R6
    {1'b1, 4'd6,  6'h0B, 4'hF, 32'hFFFFFFFF},  // R6
    {1'b0, 4'd6,  6'h0B, 4'hF, 32'h000C1073},  // R6
    {1'b1, 4'd6,  6'h11, 4'h3, 32'h0000ABCD},  // R6
    {1'b0, 4'd6,  6'h0B, 4'hF, 32'h000CABCD},  // R6
    {1'b1, 4'd6,  6'h11, 4'hC, 32'h5A5A0000},  // R6
    {1'b0, 4'd6,  6'h0B, 4'hF, 32'h5A5AABCD},  // R6
    {1'b0, 4'd6,  6'h11, 4'hF, 32'h00000000},  // R6
    {1'b0, 4'd7,  6'h0D, 4'hF, 32'h00000050},  // R7
    {1'b1, 4'd7,  6'h0D, 4'hF, 32'hFFFFFFFF},  // R7
    {1'b0, 4'd7,  6'h0D, 4'hF, 32'h00000050},  // R7
    {1'b0, 4'd9,  6'h0F, 4'hF, 32'h00000100},  // R9
    {1'b1, 4'd9,  6'h0F, 4'hF, 32'hFFFFFFFF},  // R9
    {1'b0, 4'd9,  6'h0F, 4'hF, 32'h000001FF},  // R9
    {1'b0, 4'd8,  6'h14, 4'hF, 32'h04010001},  // R8
    {1'b0, 4'd8,  6'h15, 4'hF, 32'h00000000},  // R8
    {1'b1, 4'd8,  6'h15, 4'h1, 32'h00000003},  // R8
    {1'b0, 4'd8,  6'h15, 4'hF, 32'h00000003},  // R8
    {1'b1, 4'd8,  6'h15, 4'h1, 32'h00000001},  // R8
    {1'b0, 4'd8,  6'h15, 4'hF, 32'h00000003},  // R8
    {1'b1, 4'd8,  6'h15, 4'h1, 32'h00000002},  // R8
    {1'b0, 4'd8,  6'h15, 4'hF, 32'h00000002},  // R8
    {1'b1, 4'd7,  6'h16, 4'hF, 32'hFFFFFFFF},  // R7
    {1'b0, 4'd7,  6'h16, 4'hF, 32'h00000001},  // R7
    {1'b0, 4'd7,  6'h0D, 4'hF, 32'h00000000},  // R7
    {1'b0, 4'd7,  6'h01, 4'hF, 32'h02000100},  // R7
    {1'b1, 4'd7,  6'h16, 4'h1, 32'h00000000},  // R7
    {1'b0, 4'd7,  6'h0D, 4'hF, 32'h00000050},  // R7
    {1'b0, 4'd7,  6'h01, 4'hF, 32'h02100100},  // R7
    {1'b1, 4'd10, 6'h05, 4'hF, 32'hFFFFFFFF},  // R10
    {1'b0, 4'd10, 6'h05, 4'hF, 32'h00000000},  // R10
    {1'b0, 4'd10, 6'h3F, 4'hF, 32'h00000000},  // R10
    {1'b0, 4'd10, 6'h13, 4'hF, 32'h00000000}   // R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [5:0] a, input logic [3:0] be);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a; cfg_be = be;
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: R2 R8 R12
    check("R12", cfg_rdata, 32'h0);
    check("R2", {31'h0, mem_en}, 32'h0);
    check("R2", {31'h0, bm_en}, 32'h0);
    check("R8", {30'h0, pm_state}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][46]) do_wr(VEC[i][41:36], VEC[i][35:32], VEC[i][31:0]);
      else begin
        do_rd(VEC[i][41:36], VEC[i][35:32]);
        checks++;
        if (cfg_rdata !== VEC[i][31:0]) begin
          errors++;
          $display("FAIL R%0d (vector %0d): actual %08h expected %08h",
                   VEC[i][45:42], i, cfg_rdata, VEC[i][31:0]);
        end
      end
    end
    check("R8", {30'h0, pm_state}, 32'h2);

    // R2: enables reach the ports
    do_wr(6'h01, 4'h1, 32'h00000006);
    check("R2", {30'h0, bm_en, mem_en}, 32'h3);

    // R3: event pulses set sticky bits 11..15
    @(negedge clk);
    ev_sig_tabort = 1; ev_rcv_tabort = 1; ev_rcv_mabort = 1; ev_sig_serr = 1; ev_parity_err = 1;
    @(negedge clk);
    ev_sig_tabort = 0; ev_rcv_tabort = 0; ev_rcv_mabort = 0; ev_sig_serr = 0; ev_parity_err = 0;
    do_rd(6'h01, 4'hC);
    check("R3", cfg_rdata, 32'hFA100000);
    do_wr(6'h01, 4'h8, 32'h08000000);
    do_rd(6'h01, 4'hC);
    check("R3", cfg_rdata, 32'hF2100000);
    do_wr(6'h01, 4'hC, 32'h00000000);
    do_rd(6'h01, 4'hC);
    check("R3", cfg_rdata, 32'hF2100000);
    // R3: set and clear in one cycle, set wins
    @(negedge clk);
    cfg_wr = 1; cfg_addr = 6'h01; cfg_be = 4'h8; cfg_wdata = 32'h08000000; ev_sig_tabort = 1;
    @(negedge clk);
    cfg_wr = 0; ev_sig_tabort = 0;
    do_rd(6'h01, 4'hC);
    check("R3", cfg_rdata, 32'hFA100000);

    // R4: parity response gate
    @(negedge clk); ev_master_dperr = 1;
    @(negedge clk); ev_master_dperr = 0;
    do_rd(6'h01, 4'hC);
    check("R4", cfg_rdata, 32'hFA100000);
    do_wr(6'h01, 4'h1, 32'h00000046);
    @(negedge clk); ev_master_dperr = 1;
    @(negedge clk); ev_master_dperr = 0;
    do_rd(6'h01, 4'hC);
    check("R4", cfg_rdata, 32'hFB100000);

    // R12: a write without a read leaves the read data alone
    do_wr(6'h0F, 4'h1, 32'h00000022);
    @(negedge clk);
    check("R12", cfg_rdata, 32'hFB100000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule